// File: doc/BRIEF.md
# Single-Clock FIFO with Selectable Output Timing

This block is a 36-bit-wide first-in first-out buffer. One clock times both reads and writes, and the depth is a power-of-two parameter. A master reset chooses how the read side behaves. In standard timing, a word is loaded into an output register one edge after a read request, and the status pins report empty and full. In fall-through timing, the oldest stored word is already on the output before any read is issued, and the status pins report data-available and room-available.

Two threshold flags report when the buffer is nearly drained and when it is nearly filled. Each threshold comes from one of five presets selected at master reset. It can instead be loaded from the data bus in one cycle, or shifted in one bit per clock once a serial configuration has been latched. A partial reset empties the buffer and keeps the timing mode and both thresholds. A rewind input sends the read side back to the first word written since the last reset, so that already-read data can be replayed.

Top module: `sfq_dualtime`

## Requirements
- R1: While `mrst_n` is low at a clock edge, the buffer empties, `fwft_sel` is latched as the timing mode (1 = fall-through), and `ofs_sel` is latched as the offset configuration. In standard mode the outputs afterwards are: `empty_or_ready`=1, `full_or_ready`=0, `almost_empty`=1, `almost_full`=0, `rd_data`=0. The latched mode does not change until the next master reset.
- R2: Words leave the buffer in the order they were accepted. In standard mode `empty_or_ready` is 1 exactly when nothing is stored and `full_or_ready` is 1 exactly when DEPTH words are stored. In fall-through mode `empty_or_ready` is 1 when at least one word is stored and `full_or_ready` is 1 when fewer than DEPTH words are stored.
- R3: In standard mode, a read accepted at an edge puts the oldest word on `rd_data` after that same edge. `rd_data` keeps its value in every cycle without an accepted read.
- R4: In fall-through mode, `rd_data` shows the oldest stored word without any read. A word written into an empty buffer appears on `rd_data`, with `empty_or_ready` high, right after its write edge. An accepted read moves the output to the next word.
- R5: A write while DEPTH words are stored, and a read while nothing is stored, are discarded. Such a read leaves `rd_data` unchanged in standard mode. The stored count never exceeds DEPTH.
- R6: Preset codes for `ofs_sel` at master reset are 000→8, 001→16, 010→64, 011→256 and 100→1024, and 101 and 110 give 8. One code sets both thresholds. `almost_empty` is 1 when the stored count is at or below the empty threshold. `almost_full` is 1 when DEPTH minus the count is at or below the full threshold.
- R7: If `ofs_sel`=111 at master reset, both thresholds start at 8. After that, every edge with `ofs_sel[1]`=1 shifts `ofs_sel[0]` into a 22-bit threshold register from the top, so the first bit sent ends up at the bottom. Sending 22 bits loads the empty threshold, LSB first, and then the full threshold, LSB first.
- R8: An edge with `ld_ofs`=1 loads `wr_data[10:0]` as the empty threshold and `wr_data[21:11]` as the full threshold. No word is stored on that edge even if `wr_en` is high. A parallel load takes priority over a serial shift.
- R9: While `prst_n` is low at an edge, the buffer empties and the standard output register clears. The timing mode and both thresholds are kept.
- R10: At an edge with `rt`=1, the read side returns to the first word written since the last reset, and any read on that edge is ignored. The flags then follow the restored count. Rewind is meaningful while no more than DEPTH words have been written since reset.
- R11: A read and a write accepted on the same edge both take effect, and the stored count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| mrst_n | input | 1 | Master reset, synchronous, active low |
| prst_n | input | 1 | Partial reset, synchronous, active low |
| fwft_sel | input | 1 | Timing mode sampled at master reset (1 = fall-through) |
| ofs_sel | input | 3 | Preset code at master reset; afterwards [1] = serial enable, [0] = serial bit |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Write word; also parallel threshold source |
| ld_ofs | input | 1 | Parallel threshold load |
| rd_en | input | 1 | Read request |
| rt | input | 1 | Rewind the read side to the first word since reset |
| rd_data | output | 36 | Output word |
| empty_or_ready | output | 1 | Empty (standard) or data available (fall-through) |
| full_or_ready | output | 1 | Full (standard) or room available (fall-through) |
| almost_empty | output | 1 | Count at or below the empty threshold |
| almost_full | output | 1 | Free space at or below the full threshold |

## Verification
The hardest situation to reach is a serially programmed threshold that actually changes a flag. It needs a master reset with the serial code held, then exactly 22 shift cycles with the enable bit high, then enough writes to cross the new boundary. The bench drives the shift sequence bit by bit through `ofs_sel` and then writes one word at a time across both thresholds. A bench-side model, updated on every edge, predicts each flag and output word. Rewind is reached the same way: a partial reset, a few writes, reads that leave some words behind, and then a pulse on `rt`.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
  localparam int DATA_W = 36;
  localparam int OFS_W  = 11;
  localparam logic [2:0] SEL_SERIAL = 3'b111;

  typedef enum logic {TM_STD = 1'b0, TM_FWFT = 1'b1} tmode_e;

  typedef struct packed {
    logic [OFS_W-1:0] full_ofs;
    logic [OFS_W-1:0] empty_ofs;
  } ofs_pair_t;

  function automatic logic [OFS_W-1:0] preset_offset(input logic [2:0] code);
    case (code)
      3'b001:  return OFS_W'(16);
      3'b010:  return OFS_W'(64);
      3'b011:  return OFS_W'(256);
      3'b100:  return OFS_W'(1024);
      default: return OFS_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/sfq_config.sv
module sfq_config
  import sfq_pkg::*;
(
  input  logic        clk,
  input  logic        mrst_n,
  input  logic        fwft_sel,
  input  logic [2:0]  ofs_sel,
  input  logic        ld_ofs,
  input  ofs_pair_t   ld_word,
  output tmode_e      mode,
  output ofs_pair_t   ofs
);
  logic serial_q;
  logic ser_shift;
  ofs_pair_t ofs_q;

  assign ser_shift = serial_q && ofs_sel[1] && !ld_ofs;

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      mode     <= fwft_sel ? TM_FWFT : TM_STD;
      serial_q <= (ofs_sel == SEL_SERIAL);
      ofs_q.empty_ofs <= preset_offset(ofs_sel);
      ofs_q.full_ofs  <= preset_offset(ofs_sel);
    end else if (ld_ofs) begin
      ofs_q <= ld_word;
    end else if (ser_shift) begin
      ofs_q <= ofs_pair_t'({ofs_sel[0], ofs_q[2*OFS_W-1:1]});
    end
  end

  assign ofs = ofs_q;

  // R8: a parallel load lands in both thresholds on the next cycle
  p_pload_r8: assert property (@(posedge clk) disable iff (!mrst_n)
    ld_ofs |=> (ofs == $past(ld_word)));

  // R7: a serial step moves every bit one place down and inserts at the top
  p_serial_r7: assert property (@(posedge clk) disable iff (!mrst_n)
    ser_shift |=> (ofs.full_ofs[OFS_W-1] == $past(ofs_sel[0]))
                  && (ofs.empty_ofs[OFS_W-1] == $past(ofs.full_ofs[0])));

  // R1: the timing mode only changes under master reset
  p_mode_fixed_r1: assert property (@(posedge clk) disable iff (!mrst_n)
    $past(mrst_n) |-> $stable(mode));
endmodule

// File: rtl/sfq_store.sv
module sfq_store
  import sfq_pkg::*;
#(
  parameter int DW    = 36,
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     clr,
  input  logic                     wr_go,
  input  logic                     rd_go,
  input  logic                     rewind,
  input  tmode_e                   mode,
  input  logic [DW-1:0]            wr_data,
  output logic [DW-1:0]            rd_data,
  output logic [$clog2(DEPTH):0]   count
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wr_ptr, rd_ptr;
  logic [DW-1:0] dout_q;
  logic [DW-1:0] head_word;

  assign head_word = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_go) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_go) wr_ptr <= wr_ptr + 1'b1;
      if (rewind)     rd_ptr <= '0;
      else if (rd_go) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) dout_q <= '0;
    else if (rd_go && mode == TM_STD) dout_q <= head_word;
  end

  assign rd_data = (mode == TM_FWFT) ? head_word : dout_q;
  assign count   = wr_ptr - rd_ptr;

  // R10: rewind sends the read side back to the first slot
  p_rewind_r10: assert property (@(posedge clk) disable iff (clr)
    rewind |=> (rd_ptr == '0));

  // R11: a read and a write on one edge leave the count as it was
  p_same_edge_r11: assert property (@(posedge clk) disable iff (clr)
    (wr_go && rd_go && !rewind) |=> $stable(count));

  // R5: the stored count never passes the depth
  p_count_cap_r5: assert property (@(posedge clk) disable iff (clr)
    count <= ($clog2(DEPTH)+1)'(DEPTH));
endmodule

// File: rtl/sfq_flags.sv
module sfq_flags
  import sfq_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic [$clog2(DEPTH):0] count,
  input  tmode_e                 mode,
  input  ofs_pair_t              ofs,
  output logic                   is_empty,
  output logic                   is_full,
  output logic                   almost_empty,
  output logic                   almost_full,
  output logic                   status_out,
  output logic                   status_in
);
  function automatic int free_words(input int used);
    return DEPTH - used;
  endfunction

  function automatic logic at_or_below(input int amount, input int limit);
    return amount <= limit;
  endfunction

  always_comb begin
    is_empty     = (int'(count) == 0);
    is_full      = (int'(count) == DEPTH);
    almost_empty = at_or_below(int'(count), int'(ofs.empty_ofs));
    almost_full  = at_or_below(free_words(int'(count)), int'(ofs.full_ofs));
    status_out   = (mode == TM_FWFT) ? !is_empty : is_empty;
    status_in    = (mode == TM_FWFT) ? !is_full  : is_full;
  end
endmodule

// File: rtl/sfq_dualtime.sv
module sfq_dualtime
  import sfq_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              fwft_sel,
  input  logic [2:0]        ofs_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ld_ofs,
  input  logic              rd_en,
  input  logic              rt,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty_or_ready,
  output logic              full_or_ready,
  output logic              almost_empty,
  output logic              almost_full
);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  tmode_e     mode;
  ofs_pair_t  ofs;
  logic [CNT_W-1:0] count;
  logic is_empty, is_full;
  logic clr, wr_go, rd_go;

  assign clr   = !mrst_n || !prst_n;
  assign wr_go = wr_en && !ld_ofs && !is_full && !clr;
  assign rd_go = rd_en && !rt && !is_empty && !clr;

  sfq_config u_cfg (
    .clk      (clk),
    .mrst_n   (mrst_n),
    .fwft_sel (fwft_sel),
    .ofs_sel  (ofs_sel),
    .ld_ofs   (ld_ofs),
    .ld_word  (ofs_pair_t'(wr_data[2*OFS_W-1:0])),
    .mode     (mode),
    .ofs      (ofs)
  );

  sfq_store #(.DW(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .clr     (clr),
    .wr_go   (wr_go),
    .rd_go   (rd_go),
    .rewind  (rt),
    .mode    (mode),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .count   (count)
  );

  sfq_flags #(.DEPTH(DEPTH)) u_flags (
    .count        (count),
    .mode         (mode),
    .ofs          (ofs),
    .is_empty     (is_empty),
    .is_full      (is_full),
    .almost_empty (almost_empty),
    .almost_full  (almost_full),
    .status_out   (empty_or_ready),
    .status_in    (full_or_ready)
  );

  // R5: a write into a full buffer changes nothing
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (clr)
    (wr_en && is_full && !rd_en && !rt) |=> (is_full && $stable(count)));

  // R5: a read from an empty buffer changes nothing
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (clr)
    (rd_en && is_empty && !wr_en) |=> (is_empty && $stable(rd_data)));

  // R4: in fall-through mode the first word shows up right after its write
  p_fall_through_r4: assert property (@(posedge clk) disable iff (clr)
    (mode == TM_FWFT && is_empty && wr_go) |=> empty_or_ready);

  // R3: in standard mode the output holds without an accepted read
  p_std_hold_r3: assert property (@(posedge clk) disable iff (clr)
    (mode == TM_STD && !rd_go) |=> $stable(rd_data));

  // R9: a partial reset leaves the timing mode alone
  p_prst_keep_r9: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> $stable(mode));

  // R6: threshold flags are implied by the extreme fill levels
  p_empty_ae_r6: assert property (@(posedge clk) disable iff (clr)
    is_empty |-> almost_empty);
  p_full_af_r6: assert property (@(posedge clk) disable iff (clr)
    is_full |-> almost_full);
endmodule

// File: tb/sfq_dualtime_bench.sv
module sfq_dualtime_bench;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        mrst_n = 1'b0, prst_n = 1'b1, fwft_sel = 1'b0;
  logic [2:0]  ofs_sel = 3'b000;
  logic        wr_en = 1'b0, ld_ofs = 1'b0, rd_en = 1'b0, rt = 1'b0;
  logic [35:0] wr_data = '0;
  logic [35:0] rd_data;
  logic        empty_or_ready, full_or_ready, almost_empty, almost_full;

  always #10 clk = ~clk;

  sfq_dualtime #(.DEPTH(DEPTH)) u_sfq_dualtime (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .fwft_sel(fwft_sel),
    .ofs_sel(ofs_sel), .wr_en(wr_en), .wr_data(wr_data), .ld_ofs(ld_ofs),
    .rd_en(rd_en), .rt(rt), .rd_data(rd_data),
    .empty_or_ready(empty_or_ready), .full_or_ready(full_or_ready),
    .almost_empty(almost_empty), .almost_full(almost_full)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- scoreboard model, advanced on every edge ----------------
  logic [35:0] sb_q[$];
  int          rd_idx = 0;
  bit          m_valid = 0, m_fwft = 0, m_serial = 0;
  logic [21:0] m_ofs = '0;
  logic [35:0] exp_dout = '0;

  function automatic logic [10:0] tb_preset(input logic [2:0] c);
    case (c)
      3'b000: return 11'd8;
      3'b001: return 11'd16;
      3'b010: return 11'd64;
      3'b011: return 11'd256;
      3'b100: return 11'd1024;
      default: return 11'd8;
    endcase
  endfunction

  always @(posedge clk) begin
    int  cnt;
    bit  r_fire, w_fire;
    if (!mrst_n || !prst_n) begin
      sb_q.delete();
      rd_idx   = 0;
      exp_dout = '0;
      if (!mrst_n) begin
        m_valid  = 1;
        m_fwft   = fwft_sel;
        m_serial = (ofs_sel == 3'b111);
        m_ofs    = {tb_preset(ofs_sel), tb_preset(ofs_sel)};
      end
    end else if (m_valid) begin
      cnt    = sb_q.size() - rd_idx;
      r_fire = rd_en && !rt && cnt != 0;
      w_fire = wr_en && !ld_ofs && cnt != DEPTH;
      if (r_fire) begin
        if (!m_fwft) exp_dout = sb_q[rd_idx];
        rd_idx++;
      end
      if (rt) rd_idx = 0;
      if (w_fire) sb_q.push_back(wr_data);
      if (ld_ofs) m_ofs = wr_data[21:0];
      else if (m_serial && ofs_sel[1]) m_ofs = {ofs_sel[0], m_ofs[21:1]};
    end
  end

  // monitor: compares outputs against the model mid-cycle
  always @(negedge clk) begin
    int cnt;
    if (m_valid && mrst_n && prst_n && !done) begin
      cnt = sb_q.size() - rd_idx;
      if (m_fwft) begin
        if (cnt != 0) chk("R4 fall-through data", rd_data, sb_q[rd_idx]);
        chk("R2 data-available flag", empty_or_ready, cnt != 0);
        chk("R2 room-available flag", full_or_ready, cnt != DEPTH);
      end else begin
        chk("R3 standard data", rd_data, exp_dout);
        chk("R2 empty flag", empty_or_ready, cnt == 0);
        chk("R2 full flag", full_or_ready, cnt == DEPTH);
      end
      chk("R6 almost_empty", almost_empty, cnt <= int'(m_ofs[10:0]));
      chk("R6 almost_full", almost_full, (DEPTH - cnt) <= int'(m_ofs[21:11]));
    end
  end

  // ---------------- driver ----------------
  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic mreset(input bit fw, input logic [2:0] sel);
    mrst_n = 0; fwft_sel = fw; ofs_sel = sel;
    tick(); tick();
    mrst_n = 1; ofs_sel = 3'b000;
  endtask

  task automatic preset_clear();
    prst_n = 0; tick(); prst_n = 1;
  endtask

  task automatic wr(input logic [35:0] d);
    wr_en = 1; wr_data = d; tick(); wr_en = 0;
  endtask

  task automatic rd();
    rd_en = 1; tick(); rd_en = 0;
  endtask

  task automatic wr_many(input int n, input logic [35:0] base);
    for (int i = 0; i < n; i++) wr(base + 36'(i));
  endtask

  task automatic rd_many(input int n);
    for (int i = 0; i < n; i++) rd();
  endtask

  initial begin
    logic [35:0] held;
    logic [21:0] ser_word;
    tick();
    // R1: master reset, standard timing, preset 8
    mreset(0, 3'b000);
    chk("R1 empty after reset", empty_or_ready, 1);
    chk("R1 not full after reset", full_or_ready, 0);
    chk("R1 almost_empty after reset", almost_empty, 1);
    chk("R1 almost_full after reset", almost_full, 0);
    chk("R1 data cleared", rd_data, 0);

    // R3: data only after the read edge
    wr_many(10, 36'h100);
    chk("R3 no data before read", rd_data, 0);
    rd();
    chk("R3 first word after read", rd_data, 36'h100);
    rd_many(9);

    // R11: simultaneous read and write
    wr(36'hA0A);
    wr_en = 1; rd_en = 1; wr_data = 36'hB0B; tick(); wr_en = 0; rd_en = 0;
    chk("R11 count kept at one", empty_or_ready, 0);
    chk("R11 read side advanced", rd_data, 36'hA0A);
    rd();
    chk("R11 second word", rd_data, 36'hB0B);
    chk("R11 empty afterwards", empty_or_ready, 1);

    // R5: overflow and underflow
    wr_many(DEPTH, 36'h2000);
    chk("R2 full at depth", full_or_ready, 1);
    wr(36'hBAD);
    chk("R5 still full after extra write", full_or_ready, 1);
    rd_many(DEPTH);
    chk("R5 extra write discarded", empty_or_ready, 1);
    held = rd_data;
    rd();
    chk("R5 read on empty keeps data", rd_data, held);

    // R9 (standard) and R10 retransmit
    preset_clear();
    chk("R9 partial reset empties", empty_or_ready, 1);
    chk("R9 partial reset clears output", rd_data, 0);
    wr_many(5, 36'h300);
    rd_many(3);
    rt = 1; tick(); rt = 0;
    chk("R10 flags from restored count", empty_or_ready, 0);
    chk("R10 almost_empty with 5 words", almost_empty, 1);
    rd();
    chk("R10 replay starts at first word", rd_data, 36'h300);
    rd_many(4);
    chk("R10 drained after replay", empty_or_ready, 1);

    // R8: parallel threshold load, no word stored
    preset_clear();
    wr_en = 1; ld_ofs = 1; wr_data = {14'd0, 11'd3, 11'd2}; tick();
    wr_en = 0; ld_ofs = 0;
    chk("R8 load stores no word", empty_or_ready, 1);
    wr_many(2, 36'h400);
    chk("R8 at empty threshold", almost_empty, 1);
    wr(36'h402);
    chk("R8 above empty threshold", almost_empty, 0);
    wr_many(57, 36'h403);
    chk("R8 free 4 above full threshold", almost_full, 0);
    wr(36'h4FF);
    chk("R8 free 3 at full threshold", almost_full, 1);
    preset_clear();

    // R4: fall-through mode, preset 16
    mreset(1, 3'b001);
    chk("R1 fall-through not ready", empty_or_ready, 0);
    chk("R1 fall-through room", full_or_ready, 1);
    wr(36'h5A5A);
    chk("R4 ready right after write", empty_or_ready, 1);
    chk("R4 word visible without read", rd_data, 36'h5A5A);
    wr_many(3, 36'h600);
    rd();
    chk("R4 read advances output", rd_data, 36'h600);
    rd_many(3);
    chk("R4 drained", empty_or_ready, 0);
    wr_many(16, 36'h700);
    chk("R6 preset 16 at threshold", almost_empty, 1);
    wr(36'h7FF);
    chk("R6 preset 16 above threshold", almost_empty, 0);
    // R10 in fall-through
    rt = 1; tick(); rt = 0;
    chk("R10 fall-through replay", rd_data, 36'h5A5A);

    // R9: partial reset keeps mode and threshold
    preset_clear();
    chk("R9 empties in fall-through", empty_or_ready, 0);
    wr(36'h800);
    chk("R9 still fall-through", rd_data, 36'h800);
    wr_many(15, 36'h801);
    chk("R9 threshold 16 kept", almost_empty, 1);
    wr(36'h8FF);
    chk("R9 threshold 16 kept above", almost_empty, 0);
    preset_clear();

    // R7: serial programming, empty 3 then full 5
    mreset(0, 3'b111);
    ser_word = {11'd5, 11'd3};
    for (int i = 0; i < 22; i++) begin
      ofs_sel = {1'b0, 1'b1, ser_word[i]};
      tick();
    end
    ofs_sel = 3'b000;
    wr_many(3, 36'h900);
    chk("R7 serial empty threshold at 3", almost_empty, 1);
    wr(36'h903);
    chk("R7 serial empty threshold above", almost_empty, 0);
    wr_many(54, 36'h904);
    chk("R7 free 6 above full threshold", almost_full, 0);
    wr(36'h9FF);
    chk("R7 free 5 at full threshold", almost_full, 1);

    // R6: preset 64 keeps almost_empty high even when full
    mreset(0, 3'b010);
    wr_many(DEPTH, 36'hA00);
    chk("R6 preset 64 at full", almost_empty, 1);
    chk("R6 full flag", full_or_ready, 1);
    rd_many(DEPTH);
    tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule